// File: doc/BRIEF.md
# Multiplexed LCD display RAM controller

This block holds the segment data for a multiplexed LCD: a RAM of 4 rows by 40 columns. Each column stands for one segment output and each row for one backplane phase. Bytes arrive from a serial-bus front end that has already reduced the bus traffic to a one-cycle byte-valid strobe.

The block spreads each byte over the RAM, most significant bit first. The number of bits placed in each column depends on the multiplex mode: 1 in static, 2 in 1:2, 3 in 1:3 and 4 in 1:4. Bits fill a column from row 0 downward before moving on to the next column. A column pointer advances as bytes are written, and it can be reloaded between bytes. Writing always restarts at row 0 of the addressed column, so software can reload the pointer to overwrite the tail bits of an earlier byte.

When a byte runs past the last column, the outcome depends on whether another device follows in a cascade:
- If no device follows, the extra bits are dropped.
- If a device follows, the extra bits are handed to it on an overflow output.

The block acknowledges a byte only if part of it was stored locally, or if cascade mode is set. On the read side, a row sequencer steps on a multiplex-advance strobe. On each strobe it loads the selected RAM row into a registered 40-bit segment vector.

Top module: `lcd_ram_ctrl`

## Requirements
- R1: After reset, the following hold: `ack` and `ovf_valid` are 0, `seg_out` is all zeros, `seg_row` is 0, the column pointer is 0, the sequencer row is 0 and every RAM bit is 0.
- R2: In 1:3 mode (`mode`=2), byte bits 7,6,5 go to rows 0,1,2 of the pointer column P. Bits 4,3,2 go to rows 0,1,2 of column P+1. Bits 1,0 go to rows 0,1 of column P+2. The pointer then becomes P+3.
- R3: In the other modes the byte fills columns from P onward, MSB first. Static (`mode`=0) puts 1 bit per column in row 0 and ends with the pointer at P+8. 1:2 (`mode`=1) puts 2 bits per column in rows 0,1 and ends at P+4. 1:4 (`mode`=3) puts 4 bits per column in rows 0..3 and ends at P+2.
- R4: A byte written in 1:3 mode never changes row 3.
- R5: The pointer never exceeds 40. After a byte it becomes min(P + columns touched, 40), and a partly filled last column counts as touched.
- R6: A pulse on `ptr_load` sets the pointer to `ptr_value`, clamped to 40. If `byte_valid` is high in the same cycle, that byte is written at the newly loaded pointer. A later byte overwrites every bit it maps onto, including bits of earlier bytes.
- R7: When `cascade_en` is 0, bits that map to column 40 or beyond are discarded. `ack` is then raised only if at least one bit of the byte was stored, and `ovf_valid` stays 0.
- R8: When `cascade_en` is 1, every byte is acknowledged. If any bits overflow, `ovf_valid` pulses and `ovf_mask` marks the overflowing bit positions of the byte. `ovf_bits` carries the byte ANDed with that mask.
- R9: `ack` and `ovf_valid` are one-cycle pulses, valid the clock after the `byte_valid` strobe.
- R10: Each `mux_step` outputs the current row and then advances the row. The row order is 0 only in static, 0,1 in 1:2, 0,1,2 in 1:3 and 0,1,2,3 in 1:4, wrapping each time. A current row outside the active mode's range is output as row 0.
- R11: On `mux_step`, `seg_out` bit c is loaded from the selected row at column c, and `seg_row` is loaded with that row's number. Between strobes both outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Multiplex mode: 0 static, 1 for 1:2, 2 for 1:3, 3 for 1:4 |
| cascade_en | input | 1 | A downstream device follows in the cascade |
| ptr_load | input | 1 | Load the column pointer |
| ptr_value | input | 6 | New pointer value, clamped to 40 |
| byte_valid | input | 1 | Byte strobe from the bus front end |
| byte_data | input | 8 | Byte to write |
| mux_step | input | 1 | Multiplex-advance strobe |
| ack | output | 1 | Byte acknowledge pulse |
| ovf_valid | output | 1 | Overflow bits are being handed downstream |
| ovf_bits | output | 8 | Byte masked to its overflowing bits |
| ovf_mask | output | 8 | Positions of the overflowing bits |
| seg_out | output | 40 | Registered segment vector of the selected row |
| seg_row | output | 2 | Row number held in `seg_out` |

## Verification
Some properties are checked by assertions on every cycle:
- the pulse timing of `ack` and `ovf_valid` relative to the strobe;
- that a fully lost byte gets no acknowledge outside cascade mode;
- that row 3 stays intact under 1:3 writes;
- that the pointer stays within bounds;
- that the sequencer only moves to the next row or wraps to 0, and never selects a row beyond the mode's range;
- that `seg_out` holds between strobes.

Other behaviour can only be shown by the bench's scenarios, which read the RAM back through the sequencer and compare it with a model:
- the exact placement of each bit;
- overwriting after a pointer reload;
- the overflow mask at the RAM boundary;
- pointer values reached through chains of bytes in mixed modes.

// File: rtl/lcd_ram_pkg.sv
package lcd_ram_pkg;
  localparam int ROWS = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_STATIC = 2'd0,
    MODE_MUX2   = 2'd1,
    MODE_MUX3   = 2'd2,
    MODE_MUX4   = 2'd3
  } mux_mode_e;

  // Bits stored per column, which is also the number of active rows.
  function automatic int bits_per_col(mux_mode_e m);
    return int'(m) + 1;
  endfunction

  // Columns touched by one byte (a partial column counts).
  function automatic int byte_span(mux_mode_e m);
    int b;
    b = bits_per_col(m);
    return (BYTE_W + b - 1) / b;
  endfunction

  // Sequence position (0 = MSB) of the bit landing in a cell, or -1.
  function automatic int seq_pos(int ptr, int col, int row, int bpc);
    int d;
    int p;
    d = col - ptr;
    p = d * bpc + row;
    if (d < 0 || row >= bpc || p >= BYTE_W) return -1;
    return p;
  endfunction

  // Column targeted by sequence position k.
  function automatic int seq_col(int ptr, int k, int bpc);
    return ptr + k / bpc;
  endfunction
endpackage

// File: rtl/lcd_wr_map.sv
module lcd_wr_map
  import lcd_ram_pkg::*;
#(
  parameter int COLS = 40,
  localparam int PW = $clog2(COLS + 1),
  localparam int CELLS = ROWS * COLS
) (
  input  mux_mode_e         mode,
  input  logic [PW-1:0]     ptr,
  input  logic [BYTE_W-1:0] data,
  output logic [CELLS-1:0]  wen,
  output logic [CELLS-1:0]  wbit,
  output logic              land_any,
  output logic [BYTE_W-1:0] ovf_mask,
  output logic [PW-1:0]     next_ptr
);
  int bpc;
  assign bpc = bits_per_col(mode);

  always_comb begin
    wen  = '0;
    wbit = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        int p;
        int idx;
        p = seq_pos(int'(ptr), c, r, bpc);
        idx = (p >= 0) ? (BYTE_W - 1 - p) : 0;
        wen[r*COLS+c]  = (p >= 0);
        wbit[r*COLS+c] = (p >= 0) ? data[idx] : 1'b0;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < BYTE_W; k++) begin
      ovf_mask[BYTE_W-1-k] = (seq_col(int'(ptr), k, bpc) >= COLS);
    end
  end

  assign land_any = ~(&ovf_mask);

  always_comb begin
    int np;
    np = int'(ptr) + byte_span(mode);
    if (np > COLS) np = COLS;
    next_ptr = PW'(np);
  end
endmodule

// File: rtl/lcd_ram_array.sv
module lcd_ram_array
  import lcd_ram_pkg::*;
#(
  parameter int COLS = 40,
  localparam int CELLS = ROWS * COLS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CELLS-1:0] wen,
  input  logic [CELLS-1:0] wbit,
  output logic [CELLS-1:0] mem
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [COLS-1:0] row_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q <= '0;
      end else if (we) begin
        for (int c = 0; c < COLS; c++) begin
          if (wen[r*COLS+c]) row_q[c] <= wbit[r*COLS+c];
        end
      end
    end
    assign mem[r*COLS +: COLS] = row_q;
  end
endmodule

// File: rtl/lcd_row_seq.sv
module lcd_row_seq
  import lcd_ram_pkg::*;
#(
  parameter int COLS = 40,
  localparam int CELLS = ROWS * COLS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mux_mode_e        mode,
  input  logic             step,
  input  logic [CELLS-1:0] mem,
  output logic [COLS-1:0]  seg_out,
  output logic [1:0]       seg_row
);
  logic [1:0] row;
  logic [2:0] rows_n;
  logic [1:0] eff_row;
  logic [1:0] row_nxt;

  assign rows_n  = 3'(bits_per_col(mode));
  assign eff_row = ({1'b0, row} >= rows_n) ? 2'd0 : row;
  assign row_nxt = (({1'b0, eff_row} + 3'd1) >= rows_n) ? 2'd0 : eff_row + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row     <= 2'd0;
      seg_out <= '0;
      seg_row <= 2'd0;
    end else if (step) begin
      seg_out <= mem[eff_row*COLS +: COLS];
      seg_row <= eff_row;
      row     <= row_nxt;
    end
  end

  // R10: the output row lies inside the range of the mode in force at the strobe
  a_r10_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ({1'b0, seg_row} < $past(rows_n)));
  // R10: the sequencer either moves to the next row or wraps to 0
  a_r10_row_order: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (row == 2'd0) || (row == seg_row + 2'd1));
  // R11: the segment vector holds between strobes
  a_r11_seg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(seg_out) && $stable(seg_row));
endmodule

// File: rtl/lcd_ram_ctrl.sv
module lcd_ram_ctrl
  import lcd_ram_pkg::*;
#(
  parameter int COLS = 40,
  localparam int PW = $clog2(COLS + 1),
  localparam int CELLS = ROWS * COLS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              cascade_en,
  input  logic              ptr_load,
  input  logic [PW-1:0]     ptr_value,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              mux_step,
  output logic              ack,
  output logic              ovf_valid,
  output logic [BYTE_W-1:0] ovf_bits,
  output logic [BYTE_W-1:0] ovf_mask,
  output logic [COLS-1:0]   seg_out,
  output logic [1:0]        seg_row
);
  mux_mode_e         mode_e;
  logic [PW-1:0]     ptr;
  logic [PW-1:0]     eff_ptr;
  logic [CELLS-1:0]  wen;
  logic [CELLS-1:0]  wbit;
  logic [CELLS-1:0]  mem;
  logic              land_any;
  logic [BYTE_W-1:0] map_ovf;
  logic [PW-1:0]     next_ptr;

  assign mode_e  = mux_mode_e'(mode);
  assign eff_ptr = ptr_load ? ((ptr_value > PW'(COLS)) ? PW'(COLS) : ptr_value) : ptr;

  lcd_wr_map #(.COLS(COLS)) u_map (
    .mode(mode_e), .ptr(eff_ptr), .data(byte_data),
    .wen(wen), .wbit(wbit), .land_any(land_any),
    .ovf_mask(map_ovf), .next_ptr(next_ptr)
  );

  lcd_ram_array #(.COLS(COLS)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(byte_valid),
    .wen(wen), .wbit(wbit), .mem(mem)
  );

  lcd_row_seq #(.COLS(COLS)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .step(mux_step),
    .mem(mem), .seg_out(seg_out), .seg_row(seg_row)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      ack       <= 1'b0;
      ovf_valid <= 1'b0;
      ovf_bits  <= '0;
      ovf_mask  <= '0;
    end else begin
      ack       <= byte_valid && (land_any || cascade_en);
      ovf_valid <= byte_valid && cascade_en && (|map_ovf);
      if (byte_valid) begin
        ptr      <= next_ptr;
        ovf_bits <= byte_data & map_ovf;
        ovf_mask <= map_ovf;
      end else if (ptr_load) begin
        ptr <= eff_ptr;
      end
    end
  end

  // R9: acknowledge only in the cycle after a strobe
  a_r9_ack_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(byte_valid));
  // R9: overflow hand-off also follows a strobe
  a_r9_ovf_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_valid |-> $past(byte_valid));
  // R7: a byte lost entirely past the end is not acknowledged when last in the cascade
  a_r7_no_ack_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !cascade_en && (&map_ovf)) |=> !ack);
  // R8: overflow bits leave only toward a downstream device
  a_r8_ovf_cascade_only: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_valid |-> $past(cascade_en));
  // R4: row 3 is untouched by a 1:3 write
  a_r4_row3_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && mode_e == MODE_MUX3) |=> $stable(mem[3*COLS +: COLS]));
  // R5: pointer bound
  a_r5_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PW'(COLS));
endmodule

// File: tb/tb_lcd_ram_ctrl.sv
module tb_lcd_ram_ctrl;
  localparam int COLS = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic cascade_en = 1'b0, ptr_load = 1'b0, byte_valid = 1'b0, mux_step = 1'b0;
  logic [5:0] ptr_value = '0;
  logic [7:0] byte_data = '0;
  logic ack, ovf_valid;
  logic [7:0] ovf_bits, ovf_mask;
  logic [COLS-1:0] seg_out;
  logic [1:0] seg_row;

  int n_cmp = 0;
  int n_bad = 0;
  bit mram [4][COLS];
  int mptr = 0;
  int mrow = 0;
  logic [COLS-1:0] last_seg = '0;

  lcd_ram_ctrl #(.COLS(COLS)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cascade_en(cascade_en),
    .ptr_load(ptr_load), .ptr_value(ptr_value), .byte_valid(byte_valid),
    .byte_data(byte_data), .mux_step(mux_step), .ack(ack), .ovf_valid(ovf_valid),
    .ovf_bits(ovf_bits), .ovf_mask(ovf_mask), .seg_out(seg_out), .seg_row(seg_row)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int clamp(int v);
    return (v > COLS) ? COLS : v;
  endfunction

  task automatic send(input logic [1:0] md, input logic [7:0] d, input logic casc,
                      input logic ld, input int val, input string tag);
    logic [7:0] m;
    logic landed;
    int per;
    int used;
    @(negedge clk);
    mode = md; cascade_en = casc; ptr_load = ld; ptr_value = 6'(val);
    byte_valid = 1'b1; byte_data = d;
    if (ld) mptr = clamp(val);
    per = int'(md) + 1;
    m = '0; landed = 1'b0; used = 0;
    for (int k = 0; k < 8; k++) begin
      int col;
      col = mptr + (k / per);
      if (col < COLS) begin
        mram[k % per][col] = d[7-k];
        landed = 1'b1;
      end else begin
        m[7-k] = 1'b1;
      end
      if ((k % per) == 0) used++;
    end
    mptr = clamp(mptr + used);
    @(negedge clk);
    byte_valid = 1'b0; ptr_load = 1'b0;
    chk({tag, " R9 ack"}, 64'(ack), 64'(landed || casc));
    chk({tag, " R8 ovf_valid"}, 64'(ovf_valid), 64'(casc && (m != 0)));
    if (casc && (m != 0)) begin
      chk({tag, " R8 ovf_mask"}, 64'(ovf_mask), 64'(m));
      chk({tag, " R8 ovf_bits"}, 64'(ovf_bits), 64'(d & m));
    end
    @(negedge clk);
    chk({tag, " R9 ack pulse ends"}, 64'(ack), 64'd0);
  endtask

  task automatic load_only(input int val);
    @(negedge clk);
    ptr_load = 1'b1; ptr_value = 6'(val);
    @(negedge clk);
    ptr_load = 1'b0;
    mptr = clamp(val);
  endtask

  task automatic step(input logic [1:0] md, input string tag);
    int rows;
    int er;
    logic [COLS-1:0] e;
    @(negedge clk);
    mode = md; mux_step = 1'b1;
    rows = int'(md) + 1;
    er = (mrow >= rows) ? 0 : mrow;
    for (int c = 0; c < COLS; c++) e[c] = mram[er][c];
    mrow = (er + 1 >= rows) ? 0 : er + 1;
    @(negedge clk);
    mux_step = 1'b0;
    chk({tag, " R11 seg_out"}, 64'(seg_out), 64'(e));
    chk({tag, " R10 seg_row"}, 64'(seg_row), 64'(er));
    last_seg = e;
  endtask

  task automatic dump(input string tag);
    for (int i = 0; i < 4; i++) step(2'd3, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk("R1 ack reset", 64'(ack), 64'd0);
    chk("R1 ovf reset", 64'(ovf_valid), 64'd0);
    chk("R1 seg reset", 64'(seg_out), 64'd0);
    chk("R1 row reset", 64'(seg_row), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    dump("R1 RAM zero");

    // R3 1:4 fill: every cell set to one, ending exactly at the last column
    for (int i = 0; i < 20; i++) send(2'd3, 8'hFF, 1'b0, (i == 0), 0, "R3 mux4 fill");
    dump("R3 mux4 readback");
    send(2'd3, 8'hFF, 1'b0, 1'b0, 0, "R7 pointer at end");

    // R2 R4 R6 rewrite chain in 1:3
    send(2'd2, 8'hA5, 1'b0, 1'b1, 0, "R2 byte a");
    send(2'd2, 8'h3C, 1'b0, 1'b1, 2, "R6 byte b over a");
    load_only(4);
    send(2'd2, 8'hE1, 1'b0, 1'b0, 0, "R6 byte c over b");
    send(2'd2, 8'h0F, 1'b0, 1'b0, 0, "R5 auto increment");
    dump("R4 row3 kept");

    // R3 static and 1:2
    send(2'd0, 8'h96, 1'b0, 1'b1, 10, "R3 static");
    send(2'd1, 8'h4B, 1'b0, 1'b1, 20, "R3 mux2");
    send(2'd1, 8'hD2, 1'b0, 1'b0, 0, "R5 mux2 chain");
    dump("R3 readback");

    // R7 R8 boundary
    send(2'd0, 8'h5A, 1'b0, 1'b1, 36, "R7 partial land");
    send(2'd0, 8'hC3, 1'b0, 1'b0, 0, "R7 all lost");
    send(2'd0, 8'hC3, 1'b1, 1'b0, 0, "R8 all forwarded");
    send(2'd2, 8'hB7, 1'b1, 1'b1, 38, "R8 tail forwarded");
    send(2'd1, 8'h77, 1'b0, 1'b1, 50, "R6 clamp load");
    dump("R7 boundary readback");

    // R10 sequence per mode
    for (int i = 0; i < 3; i++) step(2'd0, "R10 static");
    for (int i = 0; i < 4; i++) step(2'd1, "R10 mux2");
    for (int i = 0; i < 4; i++) step(2'd2, "R10 mux3");
    repeat (3) @(negedge clk);
    chk("R11 hold between strobes", 64'(seg_out), 64'(last_seg));

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 6) begin
        logic ld;
        ld = ($urandom_range(0, 3) == 0);
        send(2'($urandom_range(0, 3)), 8'($urandom), 1'($urandom_range(0, 1)),
             ld, $urandom_range(0, 45), "R2 R3 R6 random write");
      end else if (op < 9) begin
        step(2'($urandom_range(0, 3)), "R10 random step");
      end else begin
        load_only($urandom_range(0, 42));
      end
    end
    dump("R5 random readback");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule